// File: doc/BRIEF.md
# Hint-Driven Unit Clock Gate

This block controls the clocks of a small set of transactional units, five by default. Software writes one hint bit per unit in the register clock domain. A set bit asks for the unit's clock to run. A clear bit allows the clock to stop. The hint vector crosses into the unit clock domain through a two-flop synchronizer.

Each unit also reports an idle flag. While a unit reports busy (idle low), its clock keeps running even if its hint is clear. Two further controls act on every unit:

- A root enable from the power manager stops all unit clocks when it is low.
- A scan-mode input forces every unit clock on. It reaches the enables directly, with no flop in its path.

The resulting per-unit enable feeds a latch-based clock gate. The latch is transparent only while the unit clock is low, so a change of enable never cuts or stretches a high phase. The effective enable of each unit is synchronized back into the register clock domain as a readback vector.

Top module: `hint_clk_gate`

## Requirements
- R1: During and after a synchronous reset, every bit of `hint_q` is 1, and `clk_state` is 0 while `rst_reg` is high; once out of reset with `root_en`=1, every `unit_clk_en` bit is 1.
- R2: A cycle of `clk_reg` with `hint_wr`=1 loads `hint_wdata` into `hint_q`; the result is visible after that edge. With `hint_wr`=0, `hint_q` holds its value.
- R3: A change in `hint_q` does not affect `unit_clk_en` before the second rising edge of `clk_unit` that follows it. It is reflected within four `clk_unit` cycles.
- R4: Unit i's enable `unit_clk_en[i]` is 1 whenever `root_en`=1 and `unit_idle[i]`=0 (busy), whatever its synchronized hint. With the hint clear, the enable falls as soon as `unit_idle[i]` rises.
- R5: With `root_en`=0 and `scan_mode`=0, every `unit_clk_en` bit is 0 regardless of hints and idle flags.
- R6: With `scan_mode`=1, every `unit_clk_en` bit is 1 at once, with no clock edge needed, regardless of root enable, hints and idle flags.
- R7: `unit_clk[i]` pulses once per `clk_unit` cycle while `unit_clk_en[i]` is 1, and stays low while it is 0.
- R8: An enable change during the high phase of `clk_unit` leaves `unit_clk[i]` unchanged until `clk_unit` falls. `unit_clk[i]` is low whenever `clk_unit` is low.
- R9: `clk_state[i]` equals `unit_clk_en[i]` within four `clk_reg` cycles of the enable settling.
- R10: The units are independent: changing one unit's hint or idle flag changes only that unit's enable and gated clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-side clock |
| rst_reg | input | 1 | Synchronous active-high reset, register domain |
| clk_unit | input | 1 | Root clock of the gated units |
| rst_unit | input | 1 | Synchronous active-high reset, unit domain |
| hint_wr | input | 1 | Write strobe for the hint register |
| hint_wdata | input | NUM_UNITS | New hint vector, 1 = keep clock running |
| hint_q | output | NUM_UNITS | Current hint register contents |
| root_en | input | 1 | Root clock enable from the power manager |
| scan_mode | input | 1 | Asynchronous scan override, 1 = force all clocks on |
| unit_idle | input | NUM_UNITS | Per-unit idle flag, 0 = busy |
| unit_clk_en | output | NUM_UNITS | Effective per-unit clock enable |
| unit_clk | output | NUM_UNITS | Gated unit clocks |
| clk_state | output | NUM_UNITS | Enables synchronized into the register domain |

## Verification
The hardest case to reach is an enable that changes while the unit clock is high. A hint change cannot produce it, because the synchronizer only updates on rising edges. The bench therefore clears a unit's hint first. It then waits just past a rising edge of the unit clock and raises that unit's idle flag. The enable falls inside the high phase, and the bench checks that the gated clock completes its pulse and only then stays low. The busy hold is reached the same way. The hint is cleared while the unit is busy, the bench waits well beyond the synchronizer delay, and only then does it let the unit go idle.

// File: rtl/hint_gate_pkg.sv
package hint_gate_pkg;

    parameter int DEF_UNITS = 5;
    parameter int SYNC_DEPTH = 2;

    typedef struct packed {
        logic root;
        logic scan;
    } global_ctl_t;

    function automatic logic unit_enable(
        input global_ctl_t ctl,
        input logic        hint,
        input logic        idle
    );
        return ctl.scan | (ctl.root & (hint | ~idle));
    endfunction

endpackage

// File: rtl/hg_sync.sv
module hg_sync #(
    parameter int   WIDTH   = 5,
    parameter int   DEPTH   = hint_gate_pkg::SYNC_DEPTH,
    parameter logic RST_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_BIT}};

    logic [WIDTH-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) stage[s] <= RST_VEC;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/hg_unit_gate.sv
module hg_unit_gate
    import hint_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  global_ctl_t ctl,
    input  logic        hint,
    input  logic        idle,
    output logic        en,
    output logic        gclk
);
    logic en_lat;

    always_comb en = unit_enable(ctl, hint, idle);

    // Transparent while the source clock is low: enable is frozen in the high phase.
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;

    // R8: sampled just before each rising edge, the gated clock is low.
    a_r8_low_phase: assert property (@(posedge clk) disable iff (rst) !gclk);

endmodule

// File: rtl/hint_clk_gate.sv
module hint_clk_gate
    import hint_gate_pkg::*;
#(
    parameter int NUM_UNITS = DEF_UNITS
) (
    input  logic                 clk_reg,
    input  logic                 rst_reg,
    input  logic                 clk_unit,
    input  logic                 rst_unit,
    input  logic                 hint_wr,
    input  logic [NUM_UNITS-1:0] hint_wdata,
    output logic [NUM_UNITS-1:0] hint_q,
    input  logic                 root_en,
    input  logic                 scan_mode,
    input  logic [NUM_UNITS-1:0] unit_idle,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic [NUM_UNITS-1:0] unit_clk,
    output logic [NUM_UNITS-1:0] clk_state
);
    localparam logic [NUM_UNITS-1:0] ALL_ON = {NUM_UNITS{1'b1}};

    logic [NUM_UNITS-1:0] hint_reg;
    logic [NUM_UNITS-1:0] hint_unit;
    global_ctl_t          ctl;

    always_ff @(posedge clk_reg) begin
        if (rst_reg)      hint_reg <= ALL_ON;
        else if (hint_wr) hint_reg <= hint_wdata;
    end
    assign hint_q = hint_reg;

    hg_sync #(.WIDTH(NUM_UNITS), .RST_BIT(1'b1)) u_hint_sync (
        .clk (clk_unit),
        .rst (rst_unit),
        .d   (hint_reg),
        .q   (hint_unit)
    );

    always_comb begin
        ctl.root = root_en;
        ctl.scan = scan_mode;
    end

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        hg_unit_gate u_gate (
            .clk  (clk_unit),
            .rst  (rst_unit),
            .ctl  (ctl),
            .hint (hint_unit[i]),
            .idle (unit_idle[i]),
            .en   (unit_clk_en[i]),
            .gclk (unit_clk[i])
        );

        // R4: a busy unit under root enable keeps its clock
        a_r4_busy_holds: assert property (@(posedge clk_unit) disable iff (rst_unit)
            (root_en && !unit_idle[i]) |-> unit_clk_en[i]);
    end

    hg_sync #(.WIDTH(NUM_UNITS), .RST_BIT(1'b0)) u_state_sync (
        .clk (clk_reg),
        .rst (rst_reg),
        .d   (unit_clk_en),
        .q   (clk_state)
    );

    // R2: a write is visible after its edge
    a_r2_write_loads: assert property (@(posedge clk_reg) disable iff (rst_reg)
        hint_wr |=> (hint_q == $past(hint_wdata)));
    a_r2_hold: assert property (@(posedge clk_reg) disable iff (rst_reg)
        !hint_wr |=> $stable(hint_q));
    // R1: the first cycle out of reset sees all hints set
    a_r1_reset_hints: assert property (@(posedge clk_reg)
        rst_reg |=> (hint_q == ALL_ON));
    // R5: root enable low stops everything unless scan
    a_r5_root_off: assert property (@(posedge clk_unit) disable iff (rst_unit)
        (!root_en && !scan_mode) |-> (unit_clk_en == '0));
    // R6: scan forces every enable
    a_r6_scan_on: assert property (@(posedge clk_unit) disable iff (rst_unit)
        scan_mode |-> (unit_clk_en == ALL_ON));

endmodule

// File: tb/tb_hint_clk_gate.sv
module tb_hint_clk_gate;
    localparam int N = 5;

    logic         clk_reg = 1'b0, clk_unit = 1'b0;
    logic         rst_reg, rst_unit;
    logic         hint_wr;
    logic [N-1:0] hint_wdata, hint_q;
    logic         root_en, scan_mode;
    logic [N-1:0] unit_idle, unit_clk_en, unit_clk, clk_state;

    int n_cmp = 0, n_bad = 0;
    int edges [N];

    always #5 clk_reg = ~clk_reg;
    always #7 clk_unit = ~clk_unit;

    hint_clk_gate #(.NUM_UNITS(N)) dut (
        .clk_reg, .rst_reg, .clk_unit, .rst_unit, .hint_wr, .hint_wdata, .hint_q,
        .root_en, .scan_mode, .unit_idle, .unit_clk_en, .unit_clk, .clk_state
    );

    for (genvar g = 0; g < N; g++) begin : g_cnt
        always @(posedge unit_clk[g]) edges[g] = edges[g] + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_unit(input int n);
        repeat (n) @(posedge clk_unit);
        #1;
    endtask

    task automatic write_hint(input logic [N-1:0] v);
        @(negedge clk_reg);
        hint_wr = 1'b1;
        hint_wdata = v;
        @(posedge clk_reg);
        #1;
        hint_wr = 1'b0;
    endtask

    task automatic clear_edges();
        for (int i = 0; i < N; i++) edges[i] = 0;
    endtask

    task automatic t_reset();
        rst_reg = 1'b1; rst_unit = 1'b1;
        hint_wr = 1'b0; hint_wdata = '0;
        root_en = 1'b1; scan_mode = 1'b0; unit_idle = '1;
        repeat (4) @(posedge clk_unit);
        #1;
        check("R1 hint_q in reset", 32'(hint_q), 32'h1f);
        check("R1 clk_state in reset", 32'(clk_state), 32'h0);
        @(negedge clk_reg); rst_reg = 1'b0;
        @(negedge clk_unit); rst_unit = 1'b0;
        wait_unit(1);
        check("R1 enables after reset", 32'(unit_clk_en), 32'h1f);
    endtask

    task automatic t_write_and_sync();
        write_hint(5'b10110);
        check("R2 hint_q after write", 32'(hint_q), 32'h16);
        check("R3 enable not yet changed", 32'(unit_clk_en), 32'h1f);
        wait_unit(4);
        check("R3 enable after sync", 32'(unit_clk_en), 32'h16);
        repeat (3) @(posedge clk_reg);
        #1;
        check("R2 hint_q held", 32'(hint_q), 32'h16);
        check("R9 readback", 32'(clk_state), 32'h16);
    endtask

    task automatic t_busy_hold();
        unit_idle[0] = 1'b0;
        write_hint(5'b00000);
        wait_unit(6);
        check("R4 busy unit keeps enable", 32'(unit_clk_en), 32'h01);
        unit_idle[0] = 1'b1;
        #1;
        check("R4 enable drops on idle", 32'(unit_clk_en), 32'h00);
    endtask

    task automatic t_gated_clocks();
        write_hint(5'b01001);
        wait_unit(5);
        clear_edges();
        wait_unit(10);
        check("R7 unit0 toggling", 32'(edges[0] >= 9), 32'h1);
        check("R7 unit1 stopped", 32'(edges[1]), 32'h0);
        check("R10 unit3 toggling", 32'(edges[3] >= 9), 32'h1);
        check("R10 unit4 stopped", 32'(edges[4]), 32'h0);
        unit_idle[2] = 1'b0;
        #1;
        check("R10 only unit2 changes", 32'(unit_clk_en), 32'h0d);
        unit_idle[2] = 1'b1;
        repeat (4) @(posedge clk_reg);
        #1;
        check("R9 readback follows", 32'(clk_state), 32'h09);
    endtask

    task automatic t_glitch_free();
        unit_idle[1] = 1'b0;
        wait_unit(2);
        @(posedge clk_unit);
        #1;
        check("R8 gated high with enable", 32'(unit_clk[1]), 32'h1);
        unit_idle[1] = 1'b1;
        #1;
        check("R8 pulse not cut", 32'(unit_clk[1]), 32'h1);
        @(negedge clk_unit);
        #1;
        check("R8 low after fall", 32'(unit_clk[1]), 32'h0);
        @(posedge clk_unit);
        #1;
        check("R8 stays low next cycle", 32'(unit_clk[1]), 32'h0);
    endtask

    task automatic t_root_and_scan();
        @(negedge clk_unit);
        unit_idle = 5'b11010;
        root_en = 1'b0;
        #1;
        check("R5 root off", 32'(unit_clk_en), 32'h00);
        wait_unit(3);
        clear_edges();
        wait_unit(5);
        check("R5 no edges unit0", 32'(edges[0]), 32'h0);
        #2;
        scan_mode = 1'b1;
        #1;
        check("R6 scan forces on", 32'(unit_clk_en), 32'h1f);
        clear_edges();
        wait_unit(6);
        check("R6 clocks run in scan", 32'(edges[1] >= 5), 32'h1);
        scan_mode = 1'b0;
        root_en = 1'b1;
        unit_idle = '1;
        #1;
        check("R5 root back on", 32'(unit_clk_en), 32'h09);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_write_and_sync();
                t_busy_hold();
                t_gated_clocks();
                t_glitch_free();
                t_root_and_scan();
            end
            begin
                repeat (20000) @(posedge clk_reg);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule